// File: doc/BRIEF.md
# Target Reset Sequencer for a JTAG Debug Probe

This block produces the reset pulse that a JTAG debug probe applies to its target system, followed by a settling wait before any scan traffic may begin. A one-cycle start strobe launches a sequence. The target reset line is pulled low for a programmable number of milliseconds and then released. The block then waits a second programmable number of milliseconds and raises a ready flag, which tells the JTAG engine it may begin shifting. The reset line is open-collector, so the block only ever pulls it low or lets it float. A configuration bit can keep the block from pulling it at all. In that case the timing still runs as normal.

During the pulse the block also pulls the TAP reset line (TRST) low. Outside the pulse, TRST is either released (open-drain mode) or actively driven high (push-pull mode), as a mode bit selects. The millisecond time base comes from an internal prescaler of the system clock. The prescaler restarts at every accepted start, so every programmed millisecond is exactly the same number of clocks. All configuration is sampled at the moment a start is accepted.

Top module: `tgt_rst_seq`

## Requirements
- R1: The target reset data output `tgt_rst_do_o` is always 0. Only the enable `tgt_rst_oe_o` changes (1 = pull low). After reset, all outputs are 0: reset and TRST are released, and busy and ready are low.
- R2: When a start is accepted with a nonzero pulse setting P, `tgt_rst_oe_o` is high for exactly P·CLK_PER_MS cycles. It rises in the cycle after the start strobe is sampled.
- R3: A pulse setting of 0 selects the default length of 3 ms (DEF_PULSE_MS).
- R4: After release, the block waits W·CLK_PER_MS cycles, where W is the wake setting, and then raises `ready_o`. `busy_o` is high from the cycle after the accepted start until the cycle before `ready_o` rises, and never together with `ready_o`.
- R5: A wake setting of 0 skips the wait. `ready_o` rises in the same cycle that reset is released.
- R6: When the drive enable was 0 at start, `tgt_rst_oe_o` stays 0 for the whole sequence, and busy and ready follow the same timing as with the enable set.
- R7: While the pulse lasts, `trst_oe_o`=1 and `trst_do_o`=0. Outside it, mode 0 (open-drain) gives `trst_oe_o`=0 and `trst_do_o`=0, and mode 1 (push-pull) gives `trst_oe_o`=1 and `trst_do_o`=1.
- R8: A start strobe while `busy_o` is high is ignored. Configuration changes after acceptance do not affect the running sequence.
- R9: `ready_o` holds until the next start strobe. A start while ready launches a new sequence.
- R10: One millisecond equals CLK_PER_MS clock cycles, counted from the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run a reset sequence |
| cfg_pulse_ms_i | input | MS_W | Reset pulse length in ms (0 = default) |
| cfg_wake_ms_i | input | MS_W | Wait after release in ms (0 = none) |
| cfg_drive_en_i | input | 1 | 1 = pull target reset during the pulse |
| cfg_trst_pp_i | input | 1 | TRST driver: 0 open-drain, 1 push-pull |
| tgt_rst_oe_o | output | 1 | Target reset pull-low enable |
| tgt_rst_do_o | output | 1 | Target reset data, always 0 |
| trst_oe_o | output | 1 | TRST output enable |
| trst_do_o | output | 1 | TRST data value |
| busy_o | output | 1 | Sequence running |
| ready_o | output | 1 | Target may be accessed over JTAG |

## Verification
The assertions assume that configuration inputs matter only in the cycle a start is accepted, and that `start_i` may arrive at any time, including while a sequence runs. The bench holds configuration steady around each start, then deliberately changes it and repeats the strobe mid-sequence to probe the ignore rule. Random pulse and wake settings are kept small (0 to 5 ms) with a short prescaler, so sequences stay brief. Injected strobes always fall strictly before the ready cycle.

// File: rtl/tgt_rst_pkg.sv
package tgt_rst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PULSE = 2'd1,
    PH_WAKE  = 2'd2,
    PH_READY = 2'd3
  } phase_e;
endpackage

// File: rtl/tr_ms_tick.sv
module tr_ms_tick #(
  parameter int CLK_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R10
  pre_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/tr_phase_ctl.sv
module tr_phase_ctl
  import tgt_rst_pkg::*;
#(
  parameter int MS_W         = 8,
  parameter int DEF_PULSE_MS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            tick_i,
  input  logic [MS_W-1:0] cfg_pulse_ms_i,
  input  logic [MS_W-1:0] cfg_wake_ms_i,
  input  logic            cfg_drive_en_i,
  input  logic            cfg_pp_i,
  output logic            launch_o,
  output logic            run_o,
  output phase_e          phase_d_o,
  output logic            drive_d_o,
  output logic            pp_d_o
);
  localparam logic [MS_W-1:0] DEF_LEN = MS_W'(DEF_PULSE_MS);
  localparam logic [MS_W-1:0] ONE     = MS_W'(1);

  phase_e          phase_q, phase_d;
  logic [MS_W-1:0] mcnt_q, mcnt_d;
  logic [MS_W-1:0] plen_q, plen_d;
  logic [MS_W-1:0] wlen_q, wlen_d;
  logic            drive_q, drive_d;
  logic            pp_q, pp_d;
  logic            busy_q;

  assign busy_q   = (phase_q == PH_PULSE) || (phase_q == PH_WAKE);
  assign launch_o = start_i && !busy_q;
  assign run_o    = busy_q;

  always_comb begin
    phase_d = phase_q;
    mcnt_d  = mcnt_q;
    plen_d  = plen_q;
    wlen_d  = wlen_q;
    drive_d = drive_q;
    pp_d    = pp_q;
    if (launch_o) begin
      phase_d = PH_PULSE;
      mcnt_d  = '0;
      plen_d  = (cfg_pulse_ms_i == '0) ? DEF_LEN : cfg_pulse_ms_i;
      wlen_d  = cfg_wake_ms_i;
      drive_d = cfg_drive_en_i;
      pp_d    = cfg_pp_i;
    end else if (tick_i) begin
      case (phase_q)
        PH_PULSE: begin
          if (mcnt_q == plen_q - ONE) begin
            mcnt_d  = '0;
            phase_d = (wlen_q == '0) ? PH_READY : PH_WAKE;
          end else begin
            mcnt_d = mcnt_q + ONE;
          end
        end
        PH_WAKE: begin
          if (mcnt_q == wlen_q - ONE) begin
            mcnt_d  = '0;
            phase_d = PH_READY;
          end else begin
            mcnt_d = mcnt_q + ONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      mcnt_q  <= '0;
      plen_q  <= DEF_LEN;
      wlen_q  <= '0;
      drive_q <= 1'b0;
      pp_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mcnt_q  <= mcnt_d;
      plen_q  <= plen_d;
      wlen_q  <= wlen_d;
      drive_q <= drive_d;
      pp_q    <= pp_d;
    end
  end

  assign phase_d_o = phase_d;
  assign drive_d_o = drive_d;
  assign pp_d_o    = pp_d;

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> ($stable(plen_q) && $stable(wlen_q) && $stable(drive_q) && $stable(pp_q)));

  // R2
  pulse_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PULSE) |-> (mcnt_q < plen_q));

  // R3
  pulse_len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    plen_q != '0);
endmodule

// File: rtl/tr_pin_stage.sv
module tr_pin_stage
  import tgt_rst_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase_d_i,
  input  logic   drive_d_i,
  input  logic   pp_d_i,
  output logic   rst_oe_o,
  output logic   trst_oe_o,
  output logic   trst_do_o,
  output logic   busy_o,
  output logic   ready_o
);
  logic in_pulse;
  assign in_pulse = (phase_d_i == PH_PULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_oe_o  <= 1'b0;
      trst_oe_o <= 1'b0;
      trst_do_o <= 1'b0;
      busy_o    <= 1'b0;
      ready_o   <= 1'b0;
    end else begin
      rst_oe_o  <= in_pulse && drive_d_i;
      trst_oe_o <= in_pulse || pp_d_i;
      trst_do_o <= !in_pulse && pp_d_i;
      busy_o    <= in_pulse || (phase_d_i == PH_WAKE);
      ready_o   <= (phase_d_i == PH_READY);
    end
  end
endmodule

// File: rtl/tgt_rst_seq.sv
module tgt_rst_seq
  import tgt_rst_pkg::*;
#(
  parameter int CLK_PER_MS   = 100000,
  parameter int MS_W         = 8,
  parameter int DEF_PULSE_MS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [MS_W-1:0] cfg_pulse_ms_i,
  input  logic [MS_W-1:0] cfg_wake_ms_i,
  input  logic            cfg_drive_en_i,
  input  logic            cfg_trst_pp_i,
  output logic            tgt_rst_oe_o,
  output logic            tgt_rst_do_o,
  output logic            trst_oe_o,
  output logic            trst_do_o,
  output logic            busy_o,
  output logic            ready_o
);
  logic   tick, launch, run, drive_d, pp_d;
  phase_e phase_d;

  tr_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk(clk), .rst(rst), .clr_i(launch), .run_i(run), .tick_o(tick)
  );

  tr_phase_ctl #(.MS_W(MS_W), .DEF_PULSE_MS(DEF_PULSE_MS)) u_ctl (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick),
    .cfg_pulse_ms_i(cfg_pulse_ms_i), .cfg_wake_ms_i(cfg_wake_ms_i),
    .cfg_drive_en_i(cfg_drive_en_i), .cfg_pp_i(cfg_trst_pp_i),
    .launch_o(launch), .run_o(run), .phase_d_o(phase_d),
    .drive_d_o(drive_d), .pp_d_o(pp_d)
  );

  tr_pin_stage u_pins (
    .clk(clk), .rst(rst), .phase_d_i(phase_d), .drive_d_i(drive_d), .pp_d_i(pp_d),
    .rst_oe_o(tgt_rst_oe_o), .trst_oe_o(trst_oe_o), .trst_do_o(trst_do_o),
    .busy_o(busy_o), .ready_o(ready_o)
  );

  assign tgt_rst_do_o = 1'b0;

  // R4
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && ready_o));

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !start_i) |=> ready_o);

  // R10
  release_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_rst_oe_o) |-> $past(tick));

  // R1
  rst_pull_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_rst_oe_o |-> busy_o);

  // R7
  trst_low_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (trst_oe_o && !trst_do_o) |-> busy_o);
endmodule

// File: tb/tgt_rst_seq_bench.sv
module tgt_rst_seq_bench;
  localparam int N  = 10;
  localparam int MW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start;
  logic [MW-1:0] pulse_cfg, wake_cfg;
  logic drv_en, pp_cfg;
  logic rst_oe, rst_do, trst_oe, trst_do, busy, ready;

  int checks = 0;
  int fails  = 0;

  tgt_rst_seq #(.CLK_PER_MS(N), .MS_W(MW), .DEF_PULSE_MS(3)) u_tgt_rst_seq (
    .clk(clk), .rst(rst), .start_i(start),
    .cfg_pulse_ms_i(pulse_cfg), .cfg_wake_ms_i(wake_cfg),
    .cfg_drive_en_i(drv_en), .cfg_trst_pp_i(pp_cfg),
    .tgt_rst_oe_o(rst_oe), .tgt_rst_do_o(rst_do),
    .trst_oe_o(trst_oe), .trst_do_o(trst_do),
    .busy_o(busy), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_pulse(input int p);
    return (p == 0) ? 3 : p;
  endfunction

  task automatic run_seq(input int p, input int w, input bit drv, input bit pp, input int inj);
    int pe, tot;
    bit in_p, rdy;
    string rq;
    @(negedge clk);
    pulse_cfg = MW'(p); wake_cfg = MW'(w); drv_en = drv; pp_cfg = pp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pe  = eff_pulse(p);
    tot = (pe + w) * N;
    for (int k = 0; k <= tot + 3; k++) begin
      in_p = (k < pe * N);
      rdy  = (k >= tot);
      if (inj >= 0 && k > inj) rq = "R8";
      else if (!drv)           rq = "R6";
      else if (k == pe*N-1 || k == pe*N) rq = "R10";
      else if (p == 0)         rq = "R3";
      else                     rq = "R2";
      chk(rst_oe == (in_p && drv), rq, rst_oe, int'(in_p && drv));
      chk(rst_do == 1'b0, "R1", rst_do, 0);
      chk(busy == !rdy, (inj >= 0 && k > inj) ? "R8" : "R4", busy, int'(!rdy));
      chk(ready == rdy, (w == 0) ? "R5" : (k > tot ? "R9" : "R4"), ready, int'(rdy));
      chk(trst_oe == (in_p || pp), "R7", trst_oe, int'(in_p || pp));
      chk(trst_do == (!in_p && pp), "R7", trst_do, int'(!in_p && pp));
      if (k == inj && inj < tot) begin
        start = 1'b1; pulse_cfg = ~pulse_cfg; wake_cfg = ~wake_cfg;
        drv_en = ~drv_en; pp_cfg = ~pp_cfg;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; start = 1'b0; pulse_cfg = '0; wake_cfg = '0; drv_en = 1'b1; pp_cfg = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rst_oe == 0 && trst_oe == 0, "R1", rst_oe + 2*trst_oe, 0);
    chk(busy == 0 && ready == 0, "R1", busy + 2*ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rst_oe == 0 && busy == 0 && ready == 0, "R1", rst_oe + 2*busy + 4*ready, 0);
    run_seq(0, 2, 1'b1, 1'b0, -1);  // R3 default length
    run_seq(4, 0, 1'b1, 1'b1, -1);  // R5 zero wake, push-pull
    run_seq(2, 3, 1'b0, 1'b1, 5);   // R6 no drive, R8 mid-pulse strobe
    run_seq(1, 1, 1'b1, 1'b0, 12);  // R8 strobe in wake phase
    run_seq(1, 0, 1'b1, 1'b0, 9);   // R8 strobe on last busy cycle
    for (int i = 0; i < 12; i++) begin
      int p, w, inj;
      p = int'($urandom_range(0, 5));
      w = int'($urandom_range(0, 5));
      inj = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, N - 1)) : -1;
      run_seq(p, w, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), inj);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule